// File: doc/BRIEF.md
# SDRAM Bank Command Legality Checker

This block sits passively on the control pins of a single-data-rate SDRAM interface and samples them on every rising clock edge. It turns each cycle's pin pattern into a named command. It keeps a small state machine for each bank, and checks every command against the state of the bank or banks that the command touches. A command that the device would reject or misbehave on is reported on a one-cycle violation flag. The flag comes with a code, the bank concerned and the command itself. Legal commands move the bank machines, and illegal ones leave them untouched.

Burst ends and precharge completion are tracked with fixed, parameterised cycle counts. This lets the checker know when a bank drops back to row active or to idle without watching the data bus. It is meant for simulation monitors and for on-chip protocol guards placed beside a memory controller.

Top module: `sdram_cmd_checker`

## Requirements
- R1: Each cycle the active-low pins chip select, row strobe, column strobe and write enable are decoded, taken in that order.
  - Chip select high gives deselect (code 0).
  - LHHH gives NOP (1).
  - LHHL gives burst stop (2).
  - LHLH gives read (3), or read with auto-precharge (4) when a10 is high.
  - LHLL gives write (5), or write with auto-precharge (6) when a10 is high.
  - LLHH gives activate (7).
  - LLHL gives single-bank precharge (8) when a10 is low, and all-bank precharge (9) when a10 is high.
  - LLLH gives refresh (10).
  - LLLL gives mode register set (12).
- R2: A command is registered only when cke was high on the previous sample; otherwise the cycle decodes as deselect (0). A refresh pattern with cke high on the previous sample and low now decodes as self-refresh entry (11).
- R3: The outputs are registered and show the result for the command sampled at the latest rising edge. After reset, every bank is idle, cmd_o is 0, viol_o is 0, and the cke history reads high.
- R4: Bank states are encoded as idle 0, row active 1, reading 2, writing 3 and precharging 4. Bank i sits in bank_state_o[3*i+2:3*i]. An activate moves an idle bank to row active. An activate to a bank that is not idle is illegal, with code 2.
- R5: A read or write to a bank that is idle or precharging is illegal, with code 1.
- R6: A read or write to a row-active bank puts it in the reading or writing state for exactly BURST_LEN samples. It then goes to row active, or to precharging if auto-precharge was requested.
- R7: A single-bank precharge moves only the addressed bank to precharging, and an all-bank precharge moves every bank that is not idle. A precharging bank becomes idle after T_RP samples. A precharge to an idle bank has no effect.
- R8: A burst stop returns every bursting bank to row active and cancels any pending auto-precharge. A burst stop has no effect on banks that are not bursting.
- R9: A read or write to a bursting bank restarts its burst. A read or write to any bank ends a burst in progress in every other bank, and each such bank continues as if its burst had completed (see R6).
- R10: A refresh or a self-refresh entry is legal only when all banks are idle. Otherwise it is illegal, with code 3, and the bank reported is the lowest-numbered bank that is not idle.
- R11: A mode register set with ba[1] high is illegal, with code 5 and the addressed bank; this check takes priority. Otherwise it is illegal when any bank is not idle, with code 4 and the lowest-numbered bank that is not idle.
- R12: An illegal command changes no bank state. Banks proceed as if a NOP had been issued. viol_o is high for that one sample only, with viol_code_o, viol_bank_o and viol_cmd_o describing it. When viol_o is low, viol_code_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge samples |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | 2 | Bank address |
| a10 | input | 1 | Auto-precharge / all-bank select |
| cmd_o | output | 4 | Decoded command of the last sample |
| bank_state_o | output | 12 | Packed state of all banks |
| viol_o | output | 1 | Illegal command seen at the last sample |
| viol_code_o | output | 3 | Violation code |
| viol_bank_o | output | 2 | Bank tied to the violation |
| viol_cmd_o | output | 4 | Command that violated |

## Verification
Each pin pattern is driven from idle banks, which separates decoding from legality. Activates, reads and precharges are then driven into each bank state, so that every illegal pairing is told apart from its legal neighbour by the flag and by the unchanged bank state. Burst runs are counted sample by sample and interrupted in four ways: burst stop, a restart in the same bank, an access to another bank, and precharge. This distinguishes a plain burst end from an end with auto-precharge. Sequences with cke low check that suspended cycles are ignored, and that self-refresh entry is decoded only on a high-to-low transition.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;

    typedef enum logic [3:0] {
        CMD_DESL = 4'd0,
        CMD_NOP  = 4'd1,
        CMD_BST  = 4'd2,
        CMD_RD   = 4'd3,
        CMD_RDA  = 4'd4,
        CMD_WR   = 4'd5,
        CMD_WRA  = 4'd6,
        CMD_ACT  = 4'd7,
        CMD_PRE  = 4'd8,
        CMD_PALL = 4'd9,
        CMD_REF  = 4'd10,
        CMD_SELF = 4'd11,
        CMD_MRS  = 4'd12
    } cmd_e;

    typedef enum logic [2:0] {
        BK_IDLE   = 3'd0,
        BK_ACTIVE = 3'd1,
        BK_READ   = 3'd2,
        BK_WRITE  = 3'd3,
        BK_PRECHG = 3'd4
    } bank_e;

    typedef enum logic [2:0] {
        V_NONE      = 3'd0,
        V_RW_CLOSED = 3'd1,
        V_ACT_BUSY  = 3'd2,
        V_REF_BUSY  = 3'd3,
        V_MRS_BUSY  = 3'd4,
        V_MRS_BA1   = 3'd5
    } viol_e;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_chk_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic a10,
    input  logic cke_prev,
    input  logic cke_now,
    output cmd_e cmd
);

    always_comb begin
        cmd = CMD_DESL;
        if (cke_prev && !cs_n) begin
            case ({ras_n, cas_n, we_n})
                3'b111: cmd = CMD_NOP;
                3'b110: cmd = CMD_BST;
                3'b101: cmd = a10 ? CMD_RDA : CMD_RD;
                3'b100: cmd = a10 ? CMD_WRA : CMD_WR;
                3'b011: cmd = CMD_ACT;
                3'b010: cmd = a10 ? CMD_PALL : CMD_PRE;
                3'b001: cmd = cke_now ? CMD_REF : CMD_SELF;
                default: cmd = CMD_MRS;
            endcase
        end
    end

endmodule

// File: rtl/sdram_cmd_rules.sv
module sdram_cmd_rules
    import sdram_chk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BAW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  cmd_e           cmd,
    input  logic [BAW-1:0] ba,
    input  bank_e          st [NUM_BANKS],
    output logic           legal,
    output viol_e          code,
    output logic [BAW-1:0] vbank
);

    logic           any_busy;
    logic [BAW-1:0] first_busy;
    bank_e          tgt;

    always_comb begin
        any_busy   = 1'b0;
        first_busy = '0;
        for (int i = NUM_BANKS - 1; i >= 0; i--) begin
            if (st[i] != BK_IDLE) begin
                any_busy   = 1'b1;
                first_busy = BAW'(i);
            end
        end
    end

    assign tgt = st[ba];

    always_comb begin
        code  = V_NONE;
        vbank = ba;
        case (cmd)
            CMD_RD, CMD_RDA, CMD_WR, CMD_WRA: begin
                if (tgt == BK_IDLE || tgt == BK_PRECHG) code = V_RW_CLOSED;
            end
            CMD_ACT: begin
                if (tgt != BK_IDLE) code = V_ACT_BUSY;
            end
            CMD_REF, CMD_SELF: begin
                if (any_busy) begin
                    code  = V_REF_BUSY;
                    vbank = first_busy;
                end
            end
            CMD_MRS: begin
                if (ba[BAW-1]) begin
                    code = V_MRS_BA1;
                end else if (any_busy) begin
                    code  = V_MRS_BUSY;
                    vbank = first_busy;
                end
            end
            default: code = V_NONE;
        endcase
        legal = (code == V_NONE);
    end

endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
    import sdram_chk_pkg::*;
#(
    parameter int BURST_LEN = 4,
    parameter int T_RP      = 3,
    localparam int MAXC = (BURST_LEN > T_RP) ? BURST_LEN : T_RP,
    localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  cmd_e  cmd,
    input  logic  hit,
    output bank_e state
);

    localparam logic [CW-1:0] BL_LAST = CW'(BURST_LEN - 1);
    localparam logic [CW-1:0] RP_LAST = CW'(T_RP - 1);

    typedef struct packed {
        bank_e         state;
        logic [CW-1:0] cnt;
        logic          ap;
    } bank_t;

    bank_t r_d, r_q;
    logic  is_rw, pre_me;

    always_comb begin
        r_d    = r_q;
        is_rw  = (cmd inside {CMD_RD, CMD_RDA, CMD_WR, CMD_WRA});
        pre_me = (cmd == CMD_PRE && hit) || (cmd == CMD_PALL);
        case (r_q.state)
            BK_IDLE: begin
                if (cmd == CMD_ACT && hit) r_d.state = BK_ACTIVE;
            end
            BK_ACTIVE, BK_READ, BK_WRITE: begin
                if (is_rw && hit) begin
                    r_d.state = (cmd inside {CMD_RD, CMD_RDA}) ? BK_READ : BK_WRITE;
                    r_d.cnt   = BL_LAST;
                    r_d.ap    = (cmd inside {CMD_RDA, CMD_WRA});
                end else if (pre_me) begin
                    r_d.state = BK_PRECHG;
                    r_d.cnt   = RP_LAST;
                    r_d.ap    = 1'b0;
                end else if (r_q.state != BK_ACTIVE) begin
                    if (cmd == CMD_BST) begin
                        r_d.state = BK_ACTIVE;
                        r_d.ap    = 1'b0;
                    end else if (is_rw || r_q.cnt == '0) begin
                        r_d.state = r_q.ap ? BK_PRECHG : BK_ACTIVE;
                        r_d.cnt   = RP_LAST;
                        r_d.ap    = 1'b0;
                    end else begin
                        r_d.cnt = r_q.cnt - 1'b1;
                    end
                end
            end
            BK_PRECHG: begin
                if (r_q.cnt == '0) r_d.state = BK_IDLE;
                else               r_d.cnt   = r_q.cnt - 1'b1;
            end
            default: r_d.state = BK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: BK_IDLE, cnt: '0, ap: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign state = r_q.state;

    AST_ACT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == BK_ACTIVE && $past(r_q.state) == BK_IDLE)
        |-> ($past(cmd) == CMD_ACT && $past(hit))); // R4

    AST_IDLE_FROM_PRECHG: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == BK_IDLE && $past(r_q.state) != BK_IDLE)
        |-> ($past(r_q.state) == BK_PRECHG)); // R7

    AST_READ_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == BK_READ && $past(r_q.state) != BK_READ)
        |-> ($past(cmd) inside {CMD_RD, CMD_RDA} && $past(hit))); // R6

    AST_BST_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_BST) |=> (r_q.state != BK_READ && r_q.state != BK_WRITE)); // R8

endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
    import sdram_chk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BURST_LEN = 4,
    parameter int T_RP      = 3,
    localparam int BAW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic                   cke,
    input  logic [BAW-1:0]         ba,
    input  logic                   a10,
    output logic [3:0]             cmd_o,
    output logic [3*NUM_BANKS-1:0] bank_state_o,
    output logic                   viol_o,
    output logic [2:0]             viol_code_o,
    output logic [BAW-1:0]         viol_bank_o,
    output logic [3:0]             viol_cmd_o
);

    typedef struct packed {
        cmd_e           cmd;
        logic           viol;
        viol_e          code;
        logic [BAW-1:0] vbank;
        cmd_e           vcmd;
        logic           cke;
    } top_t;

    top_t           r_d, r_q;
    cmd_e           cmd_dec, cmd_eff;
    logic           legal;
    viol_e          code;
    logic [BAW-1:0] vbank;
    bank_e          st [NUM_BANKS];

    sdram_cmd_decode u_dec (
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .a10      (a10),
        .cke_prev (r_q.cke),
        .cke_now  (cke),
        .cmd      (cmd_dec)
    );

    sdram_cmd_rules #(.NUM_BANKS(NUM_BANKS)) u_rules (
        .cmd   (cmd_dec),
        .ba    (ba),
        .st    (st),
        .legal (legal),
        .code  (code),
        .vbank (vbank)
    );

    assign cmd_eff = legal ? cmd_dec : CMD_NOP;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        sdram_bank_track #(.BURST_LEN(BURST_LEN), .T_RP(T_RP)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .cmd   (cmd_eff),
            .hit   (ba == BAW'(g)),
            .state (st[g])
        );
        assign bank_state_o[3*g +: 3] = st[g];
    end

    always_comb begin
        r_d       = r_q;
        r_d.cmd   = cmd_dec;
        r_d.viol  = !legal;
        r_d.code  = code;
        r_d.vbank = legal ? '0 : vbank;
        r_d.vcmd  = legal ? CMD_DESL : cmd_dec;
        r_d.cke   = cke;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{cmd: CMD_DESL, viol: 1'b0, code: V_NONE, vbank: '0,
                     vcmd: CMD_DESL, cke: 1'b1};
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_o       = r_q.cmd;
    assign viol_o      = r_q.viol;
    assign viol_code_o = r_q.code;
    assign viol_bank_o = r_q.vbank;
    assign viol_cmd_o  = r_q.vcmd;

    AST_VIOL_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |-> (viol_code_o != 3'd0)); // R12

    AST_VIOL_CMD_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |-> !(cmd_o inside {CMD_DESL, CMD_NOP, CMD_BST, CMD_PRE, CMD_PALL})); // R12

    AST_SUSPEND_DESL: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(r_q.cke) |-> (r_q.cmd == CMD_DESL)); // R2

    AST_SELF_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cmd == CMD_SELF) |-> ($past(r_q.cke) && !r_q.cke)); // R2

    AST_REF_ALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o inside {CMD_REF, CMD_SELF} && !viol_o) |-> (bank_state_o == '0)); // R10

endmodule

// File: tb/tb_sdram_cmd_checker.sv
module tb_sdram_cmd_checker;

    localparam int C_DESL = 0, C_NOP = 1, C_BST = 2, C_RD = 3, C_RDA = 4,
                   C_WR = 5, C_WRA = 6, C_ACT = 7, C_PRE = 8, C_PALL = 9,
                   C_REF = 10, C_SELF = 11, C_MRS = 12;
    localparam int S_IDLE = 0, S_ACT = 1, S_RD = 2, S_WR = 3, S_PRE = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic        cke = 1'b1;
    logic [1:0]  ba = '0;
    logic        a10 = 1'b0;
    logic [3:0]  cmd_o;
    logic [11:0] bank_state_o;
    logic        viol_o;
    logic [2:0]  viol_code_o;
    logic [1:0]  viol_bank_o;
    logic [3:0]  viol_cmd_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sdram_cmd_checker dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .cke(cke), .ba(ba), .a10(a10), .cmd_o(cmd_o),
        .bank_state_o(bank_state_o), .viol_o(viol_o), .viol_code_o(viol_code_o),
        .viol_bank_o(viol_bank_o), .viol_cmd_o(viol_cmd_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_bank(input string req, input int b, input int exp);
        chk(req, $sformatf("bank%0d state", b), int'(bank_state_o[3*b +: 3]), exp);
    endtask

    task automatic chk_viol(input string req, input int code, input int bnk, input int c);
        chk(req, "viol flag", int'(viol_o), 1);
        chk(req, "viol code", int'(viol_code_o), code);
        chk(req, "viol bank", int'(viol_bank_o), bnk);
        chk(req, "viol cmd", int'(viol_cmd_o), c);
    endtask

    task automatic issue(input int c, input int b, input logic k);
        @(negedge clk);
        cke = k;
        ba = 2'(b);
        a10 = 1'b0;
        cs_n = 1'b0;
        case (c)
            C_NOP:  {ras_n, cas_n, we_n} = 3'b111;
            C_BST:  {ras_n, cas_n, we_n} = 3'b110;
            C_RD:   {ras_n, cas_n, we_n} = 3'b101;
            C_RDA:  begin {ras_n, cas_n, we_n} = 3'b101; a10 = 1'b1; end
            C_WR:   {ras_n, cas_n, we_n} = 3'b100;
            C_WRA:  begin {ras_n, cas_n, we_n} = 3'b100; a10 = 1'b1; end
            C_ACT:  {ras_n, cas_n, we_n} = 3'b011;
            C_PRE:  {ras_n, cas_n, we_n} = 3'b010;
            C_PALL: begin {ras_n, cas_n, we_n} = 3'b010; a10 = 1'b1; end
            C_REF:  {ras_n, cas_n, we_n} = 3'b001;
            C_MRS:  {ras_n, cas_n, we_n} = 3'b000;
            default: begin cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b111; end
        endcase
        @(posedge clk);
        #2;
    endtask

    task automatic nops(input int n);
        for (int i = 0; i < n; i++) issue(C_NOP, 0, 1'b1);
    endtask

    task automatic t_reset;
        chk("R3", "reset cmd", int'(cmd_o), C_DESL);
        chk("R3", "reset viol", int'(viol_o), 0);
        chk("R3", "reset banks", int'(bank_state_o), 0);
    endtask

    task automatic t_decode;
        issue(C_NOP, 0, 1'b1);  chk("R1", "nop code", int'(cmd_o), C_NOP);
        issue(C_BST, 0, 1'b1);  chk("R1", "bst code", int'(cmd_o), C_BST);
        chk("R8", "bst idle banks", int'(bank_state_o), 0);
        issue(C_MRS, 1, 1'b1);  chk("R1", "mrs code", int'(cmd_o), C_MRS);
        chk("R11", "mrs idle legal", int'(viol_o), 0);
        issue(C_REF, 0, 1'b1);  chk("R1", "ref code", int'(cmd_o), C_REF);
        chk("R10", "ref idle legal", int'(viol_o), 0);
        issue(C_PRE, 3, 1'b1);  chk("R1", "pre code", int'(cmd_o), C_PRE);
        chk_bank("R7", 3, S_IDLE);
        issue(C_DESL, 0, 1'b1); chk("R1", "desl code", int'(cmd_o), C_DESL);
    endtask

    task automatic t_burst;
        issue(C_ACT, 1, 1'b1);
        chk("R1", "act code", int'(cmd_o), C_ACT);
        chk_bank("R4", 1, S_ACT);
        issue(C_RD, 1, 1'b1);
        chk("R1", "rd code", int'(cmd_o), C_RD);
        chk_bank("R6", 1, S_RD);
        nops(3); chk_bank("R6", 1, S_RD);
        nops(1); chk_bank("R6", 1, S_ACT);
        issue(C_WRA, 1, 1'b1);
        chk("R1", "wra code", int'(cmd_o), C_WRA);
        chk_bank("R6", 1, S_WR);
        nops(3); chk_bank("R6", 1, S_WR);
        nops(1); chk_bank("R6", 1, S_PRE);
        nops(2); chk_bank("R7", 1, S_PRE);
        nops(1); chk_bank("R7", 1, S_IDLE);
    endtask

    task automatic t_illegal;
        issue(C_RD, 2, 1'b1);
        chk_viol("R5", 1, 2, C_RD);
        chk_bank("R12", 2, S_IDLE);
        nops(1); chk("R12", "flag one cycle", int'(viol_o), 0);
        chk("R12", "code cleared", int'(viol_code_o), 0);
        issue(C_ACT, 0, 1'b1);
        chk("R4", "first act legal", int'(viol_o), 0);
        issue(C_ACT, 0, 1'b1);
        chk_viol("R4", 2, 0, C_ACT);
        chk_bank("R12", 0, S_ACT);
        issue(C_REF, 0, 1'b1);
        chk_viol("R10", 3, 0, C_REF);
        issue(C_MRS, 2, 1'b1);
        chk_viol("R11", 5, 2, C_MRS);
        issue(C_MRS, 1, 1'b1);
        chk_viol("R11", 4, 0, C_MRS);
        issue(C_PRE, 0, 1'b1);
        chk_bank("R7", 0, S_PRE);
        issue(C_WR, 0, 1'b1);
        chk_viol("R5", 1, 0, C_WR);
        chk_bank("R12", 0, S_PRE);
        nops(1); chk_bank("R7", 0, S_PRE);
        nops(1); chk_bank("R7", 0, S_IDLE);
    endtask

    task automatic t_interrupt;
        issue(C_ACT, 0, 1'b1);
        issue(C_ACT, 1, 1'b1);
        issue(C_RDA, 0, 1'b1);
        nops(1);
        issue(C_BST, 3, 1'b1);
        chk_bank("R8", 0, S_ACT);
        chk_bank("R8", 1, S_ACT);
        nops(5); chk_bank("R8", 0, S_ACT);
        issue(C_RD, 0, 1'b1);
        issue(C_WR, 1, 1'b1);
        chk_bank("R9", 1, S_WR);
        chk_bank("R9", 0, S_ACT);
        issue(C_RDA, 0, 1'b1);
        chk_bank("R9", 0, S_RD);
        chk_bank("R9", 1, S_ACT);
        nops(2);
        issue(C_RD, 0, 1'b1);
        nops(3); chk_bank("R9", 0, S_RD);
        nops(1); chk_bank("R9", 0, S_ACT);
        issue(C_WRA, 1, 1'b1);
        issue(C_RD, 0, 1'b1);
        chk_bank("R9", 1, S_PRE);
        chk_bank("R9", 0, S_RD);
        issue(C_PALL, 0, 1'b1);
        chk("R1", "pall code", int'(cmd_o), C_PALL);
        chk_bank("R7", 0, S_PRE);
        chk_bank("R7", 1, S_PRE);
        nops(3);
        chk("R7", "all idle after pall", int'(bank_state_o), 0);
    endtask

    task automatic t_single_pre;
        issue(C_ACT, 2, 1'b1);
        issue(C_ACT, 3, 1'b1);
        issue(C_PRE, 2, 1'b1);
        chk_bank("R7", 2, S_PRE);
        chk_bank("R7", 3, S_ACT);
        issue(C_PRE, 3, 1'b1);
        nops(3);
        chk("R7", "idle after pre", int'(bank_state_o), 0);
    endtask

    task automatic t_cke;
        issue(C_REF, 0, 1'b0);
        chk("R2", "self entry", int'(cmd_o), C_SELF);
        chk("R10", "self idle legal", int'(viol_o), 0);
        issue(C_ACT, 0, 1'b0);
        chk("R2", "suspended cmd", int'(cmd_o), C_DESL);
        chk_bank("R2", 0, S_IDLE);
        issue(C_ACT, 0, 1'b1);
        chk("R2", "exit cycle ignored", int'(cmd_o), C_DESL);
        chk_bank("R2", 0, S_IDLE);
        issue(C_ACT, 0, 1'b1);
        chk_bank("R2", 0, S_ACT);
        issue(C_REF, 0, 1'b0);
        chk_viol("R10", 3, 0, C_SELF);
        issue(C_NOP, 0, 1'b1);
        issue(C_PRE, 0, 1'b1);
        nops(3);
        chk("R7", "idle after cke test", int'(bank_state_o), 0);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(posedge clk); #2;
        t_reset;
        t_decode;
        t_burst;
        t_illegal;
        t_interrupt;
        t_single_pre;
        t_cke;
        summary;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary;
    end

endmodule